// File: doc/BRIEF.md
# Rotary dial zero-landing counter

This block models the dial of a combination lock. The dial has a fixed ring of positions and holds its current position in a register. A driver presents one instruction at a time. Each instruction is a direction and a click count, and the driver captures it with a valid strobe that lasts one clock. The block then turns the dial by one click on each clock in the requested direction, wrapping at the ends of the ring. When the clicks of an instruction are used up, the block checks where the dial rests. If it rests at position 0, a zero tally goes up by one.

The edge of the block has no handshake. The driver must leave a fixed gap between instructions that is longer than the largest click count plus a small margin. The current dial position is brought out next to the tally so that the dial can be watched as it moves. A synchronous reset places every register in its power-up state.

Top module: `rotary_dial_zero_counter`

## Requirements
- R1: While `rst` is high, and after it is released with no instruction given, `dial_pos` reads 50 and `zero_count` reads 0.
- R2: On a clock edge where `in_valid` is 1, the block captures `in_clicks` and `in_dir`. `in_dir` = 1 turns the dial right, which increments the position. `in_dir` = 0 turns it left, which decrements the position. The dial does not move on the capture edge.
- R3: After a capture of N clicks, the dial moves exactly one position on each of the next N clock edges. It then holds still.
- R4: The dial has 100 positions, 0 to 99. A right step from 99 goes to 0, and a left step from 0 goes to 99. `dial_pos` is never above 99.
- R5: The clock edge after the last step of an instruction increments `zero_count` by one if `dial_pos` is 0. Positions at 0 that are passed during the rotation are not counted.
- R6: An instruction of 0 clicks leaves the dial where it is. On the edge after the capture, it increments `zero_count` if the dial is already at 0.
- R7: Each instruction triggers the zero check exactly once. `zero_count` stays unchanged from then until the next instruction is completed.
- R8: A valid strobe that arrives while a rotation is still in progress replaces the remaining clicks and the direction. The old instruction gets no zero check, and the dial continues under the new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to power-up values |
| in_valid | input | 1 | One-cycle strobe that captures an instruction |
| in_dir | input | 1 | Direction: 1 = right (increment), 0 = left (decrement) |
| in_clicks | input | 10 | Click count of the instruction |
| dial_pos | output | 7 | Current dial position, 0 to 99 |
| zero_count | output | 11 | Number of instructions that ended at position 0 |

## Verification
A fault in the remaining-click count or the captured direction appears on `dial_pos` within a clock or two of the capture, as a wrong stepping rate or a wrong direction. By the end of the instruction it leaves a final position that differs from the modular model. A fault in the wrap or in the completion flag is seen only when an instruction ends. At that point `zero_count` either misses an increment or gains an extra one, and the error stays in every later comparison because the tally accumulates. The bench therefore samples both outputs at the exact completion edge, in the middle of rotations, and after landings that are forced onto position 0.

// File: rtl/dial_pkg.sv
package dial_pkg;
   typedef enum logic {
      TURN_LEFT  = 1'b0,
      TURN_RIGHT = 1'b1
   } turn_e;
endpackage

// File: rtl/dial_click_counter.sv
module dial_click_counter
   import dial_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             dir_in,
   input  logic [CNT_W-1:0] clicks_in,
   output logic             step,
   output turn_e            step_dir,
   output logic             done
);
   initial begin
      if (CNT_W < 1) $error("CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] left_q;
   turn_e            dir_q;
   logic             pending_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         left_q    <= '0;
         dir_q     <= TURN_LEFT;
         pending_q <= 1'b0;
      end else if (load) begin
         left_q    <= clicks_in;
         dir_q     <= turn_e'(dir_in);
         pending_q <= 1'b1;
      end else if (left_q != '0) begin
         left_q    <= left_q - 1'b1;
      end else if (pending_q) begin
         pending_q <= 1'b0;
      end
   end

   assign step     = (left_q != '0) && !load;
   assign step_dir = dir_q;
   assign done     = pending_q && (left_q == '0);

   // R7
   done_once_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> (!done || $past(load)));

   // R6
   zero_click_done_chk: assert property (@(posedge clk) disable iff (rst)
      (load && clicks_in == '0) |=> done);

   // R8
   reload_dir_chk: assert property (@(posedge clk) disable iff (rst)
      (load && clicks_in != '0) |=> (step_dir == turn_e'($past(dir_in))));
endmodule

// File: rtl/dial_position.sv
module dial_position
   import dial_pkg::*;
#(
   parameter int POS_W     = 7,
   parameter int POSITIONS = 100,
   parameter int START_POS = 50
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  turn_e            step_dir,
   output logic [POS_W-1:0] pos
);
   localparam logic [POS_W-1:0] LAST  = POS_W'(POSITIONS - 1);
   localparam logic [POS_W-1:0] START = POS_W'(START_POS);

   initial begin
      if (POSITIONS < 2 || POSITIONS > (1 << POS_W))
         $error("POSITIONS does not fit POS_W");
      if (START_POS < 0 || START_POS >= POSITIONS)
         $error("START_POS out of range");
   end

   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] up_v;
   logic [POS_W-1:0] dn_v;

   generate
      if (POSITIONS == (1 << POS_W)) begin : g_pow2
         assign up_v = pos_q + 1'b1;
         assign dn_v = pos_q - 1'b1;
      end else begin : g_mod
         assign up_v = (pos_q == LAST) ? '0 : pos_q + 1'b1;
         assign dn_v = (pos_q == '0) ? LAST : pos_q - 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       pos_q <= START;
      else if (step) pos_q <= (step_dir == TURN_RIGHT) ? up_v : dn_v;
   end

   assign pos = pos_q;

   // R4
   pos_range_chk: assert property (@(posedge clk) disable iff (rst)
      pos_q <= LAST);

   // R3
   step_moves_chk: assert property (@(posedge clk) disable iff (rst)
      step |=> (pos_q != $past(pos_q)));

   // R3
   idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(pos_q));
endmodule

// File: rtl/dial_zero_tally.sv
module dial_zero_tally #(
   parameter int POS_W   = 7,
   parameter int TALLY_W = 11
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               done,
   input  logic [POS_W-1:0]   pos,
   output logic [TALLY_W-1:0] tally
);
   initial begin
      if (TALLY_W < 1) $error("TALLY_W must be at least 1");
   end

   logic [TALLY_W-1:0] tally_q;

   always_ff @(posedge clk) begin
      if (rst)                          tally_q <= '0;
      else if (done && pos == '0)       tally_q <= tally_q + 1'b1;
   end

   assign tally = tally_q;

   // R5
   tally_cause_chk: assert property (@(posedge clk) disable iff (rst)
      (tally_q != $past(tally_q)) |-> ($past(done) && $past(pos) == '0));

   // R7
   tally_unit_chk: assert property (@(posedge clk) disable iff (rst)
      (tally_q != $past(tally_q)) |-> (tally_q == $past(tally_q) + 1'b1));
endmodule

// File: rtl/rotary_dial_zero_counter.sv
module rotary_dial_zero_counter
   import dial_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int POS_W     = 7,
   parameter int TALLY_W   = 11,
   parameter int POSITIONS = 100,
   parameter int START_POS = 50
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic               in_dir,
   input  logic [CNT_W-1:0]   in_clicks,
   output logic [POS_W-1:0]   dial_pos,
   output logic [TALLY_W-1:0] zero_count
);
   logic  step;
   turn_e step_dir;
   logic  done;

   dial_click_counter #(.CNT_W(CNT_W)) u_clicks (
      .clk(clk), .rst(rst), .load(in_valid), .dir_in(in_dir),
      .clicks_in(in_clicks), .step(step), .step_dir(step_dir), .done(done)
   );

   dial_position #(.POS_W(POS_W), .POSITIONS(POSITIONS), .START_POS(START_POS)) u_pos (
      .clk(clk), .rst(rst), .step(step), .step_dir(step_dir), .pos(dial_pos)
   );

   dial_zero_tally #(.POS_W(POS_W), .TALLY_W(TALLY_W)) u_tally (
      .clk(clk), .rst(rst), .done(done), .pos(dial_pos), .tally(zero_count)
   );

   // R2
   capture_holds_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> $stable(dial_pos));
endmodule

// File: tb/rotary_dial_zero_counter_tb_top.sv
module rotary_dial_zero_counter_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_dir = 1'b0;
   logic [9:0]  in_clicks = '0;
   logic [6:0]  dial_pos;
   logic [10:0] zero_count;

   int total = 0;
   int bad   = 0;
   int m_pos = 50;
   int m_zero = 0;

   always #5 clk = ~clk;

   rotary_dial_zero_counter dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_dir(in_dir),
      .in_clicks(in_clicks), .dial_pos(dial_pos), .zero_count(zero_count)
   );

   function automatic int turn(int p, bit d, int n);
      if (d) return (p + n) % 100;
      return ((p - (n % 100)) + 100) % 100;
   endfunction

   task automatic check(string req, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // strobe valid over one edge; returns at the negedge after the capture edge
   task automatic strobe(bit d, int n);
      @(negedge clk);
      in_valid  = 1'b1;
      in_dir    = d;
      in_clicks = 10'(n);
      @(posedge clk);
      @(negedge clk);
      in_valid  = 1'b0;
   endtask

   task automatic edges(int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_instr(string req, bit d, int n);
      strobe(d, n);
      edges(n + 1);
      m_pos = turn(m_pos, d, n);
      if (m_pos == 0) m_zero++;
      check({req, " pos"}, dial_pos, m_pos);
      check({req, " tally"}, zero_count, m_zero);
      edges(2);
   endtask

   initial begin
      #(200000 * 10);
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2025);
      edges(3);
      check("R1 reset pos", dial_pos, 50);
      check("R1 reset tally", zero_count, 0);
      rst = 1'b0;
      edges(3);
      check("R1 idle pos", dial_pos, 50);
      check("R1 idle tally", zero_count, 0);

      // R2 capture edge does not move; R3 one step per edge
      strobe(1'b1, 30);
      check("R2 no move on capture", dial_pos, 50);
      edges(5);
      check("R3 five steps right", dial_pos, 55);
      edges(26);
      check("R3 held after 30", dial_pos, 80);
      m_pos = 80;
      edges(2);
      check("R3 still held", dial_pos, 80);

      // R5 landing on zero: exact completion edge
      strobe(1'b1, 20);
      edges(20);
      check("R4 wrap right to 0", dial_pos, 0);
      check("R5 tally before check edge", zero_count, 0);
      edges(1);
      check("R5 tally at check edge", zero_count, 1);
      m_pos = 0; m_zero = 1;
      edges(5);
      check("R7 tally held", zero_count, 1);

      // R4 left wrap from 0
      strobe(1'b0, 1);
      edges(2);
      check("R4 wrap left to 99", dial_pos, 99);
      m_pos = 99;

      // R5 passing zero is not counted
      run_instr("R5 pass through zero", 1'b1, 50);
      run_instr("R5 pass through zero left", 1'b0, 150);

      // R6 zero clicks at nonzero, then at zero
      run_instr("R6 zero clicks nonzero", 1'b1, 0);
      run_instr("R2 go to zero", 1'b0, m_pos);
      run_instr("R6 zero clicks at zero", 1'b0, 0);
      check("R7 single count", zero_count, m_zero);

      // R8 overwrite mid-rotation
      strobe(1'b1, 200);
      edges(9);
      strobe(1'b0, 3);
      check("R8 moved before overwrite", dial_pos, turn(m_pos, 1'b1, 10));
      edges(4);
      m_pos = turn(turn(m_pos, 1'b1, 10), 1'b0, 3);
      if (m_pos == 0) m_zero++;
      check("R8 final pos", dial_pos, m_pos);
      check("R8 tally", zero_count, m_zero);
      edges(2);

      run_instr("R3 max clicks", 1'b1, 1023);

      for (int k = 0; k < 40; k++) begin
         bit d;
         int n;
         d = 1'($urandom_range(0, 1));
         if ($urandom_range(0, 2) == 0)
            n = (d ? (100 - m_pos) % 100 : m_pos) + 100 * $urandom_range(0, 2);
         else
            n = $urandom_range(0, 260);
         run_instr("R5 random", d, n);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule